// File: doc/BRIEF.md
# Multi-Scheme Gray-Coded Symbol Mapper

This block is the mapping stage of a small baseband transmitter. A serial stream of already coded bits comes in over a valid/ready handshake. The bits are grouped into symbols of 1, 2, 4 or 8 bits, depending on the active modulation scheme. Each symbol becomes a pair of signed in-phase and quadrature amplitudes. The mapper multiplies these amplitudes, sample by sample, with externally supplied cosine and sine carrier samples. The results are two product streams for a pair of DACs.

The scheme comes from a four-bit push-button word. An all-clear word selects the two-level default, which is also what the first button selects. The other three buttons select the four-point, sixteen-point and 256-point constellations. A symbol holds for a fixed number of carrier samples, called the symbol period. The block loads a new symbol, and applies a new scheme, only where one symbol period ends and the next begins. Amplitudes are signed fixed point with four fractional bits, so every level is exact.

Top module: `qam_symbol_mapper`

## Requirements
- R1: While reset is held, `scheme` is 0, `out_valid` is 0, both products are 0 and `bit_ready` is 1. All amplitudes are zero until the first symbol boundary.
- R2: The button word decodes to a scheme code as follows: `0000` or `1000` gives 0 (two-level), `0100` gives 1 (four-point), `0010` gives 2 (sixteen-point), `0001` gives 3 (256-point). The code appears on `scheme` at the next symbol boundary.
- R3: A button word with more than one bit set is ignored. The pending scheme keeps its previous value.
- R4: `scheme` and both amplitudes change only at a symbol boundary. A boundary is the edge that takes the SPS-th accepted carrier sample of a symbol period. Products of that sample still use the old amplitudes.
- R5: The block accepts bits while it holds fewer than the symbol size of the pending scheme (1, 2, 4 or 8 bits). The first bit received is the most significant bit of the symbol. A boundary that finds a full symbol consumes it and empties the collector.
- R6: Scheme 0: a bit value of 1 gives I = +2/16 and 0 gives I = -2/16. Q is 0.
- R7: Scheme 1: symbol bit 1 sets the sign of I and bit 0 sets the sign of Q (1 = positive). Both magnitudes are 3/16.
- R8: Scheme 2: bits 3:2 drive I and bits 1:0 drive Q. In each pair the upper bit is the sign (1 = positive). The lower bit selects the magnitude: 0 gives 5/16 and 1 gives 14/16.
- R9: Scheme 3: bits 7:4 drive I and bits 3:0 drive Q. Each nibble selects an odd level L and the amplitude is L×16/16. The ascending levels -15, -13, …, +15 are given by codes 0001, 0000, 0010, 0011, 0111, 0110, 0100, 0101, 1101, 1100, 1110, 1111, 1011, 1010, 1000, 1001.
- R10: For each accepted carrier sample, the next edge registers `i_out` = I amplitude × `cos_in` and `q_out` = Q amplitude × `sin_in`. `out_valid` is `car_valid` delayed by one cycle.
- R11: A boundary that finds fewer bits than one symbol loads zero amplitudes on both branches. The partial bits stay in the collector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn | input | 4 | Button word; btn[3] is the first button |
| bit_data | input | 1 | Serial coded bit |
| bit_valid | input | 1 | Bit offered |
| bit_ready | output | 1 | Bit accepted when high with bit_valid |
| car_valid | input | 1 | Carrier sample strobe |
| cos_in | input | CAR_W | Signed cosine carrier sample |
| sin_in | input | CAR_W | Signed sine carrier sample |
| out_valid | output | 1 | Products updated this cycle |
| i_out | output | AMP_W+CAR_W | Signed in-phase product |
| q_out | output | AMP_W+CAR_W | Signed quadrature product |
| scheme | output | 2 | Active scheme code |

## Verification
The bench builds the mapper with a 16-sample symbol period and 8-bit carrier samples. The short period gives over a thousand symbol boundaries in one run, so every scheme and every 256-point Gray code is reached many times. It also covers scheme changes in the middle of a collection, where the pending scheme shrinks or grows. With 8-bit carriers the most negative and most positive samples are easy to drive directly, which checks the signed product at both extremes of the 256-point levels.

// File: rtl/qam_symbol_mapper.sv
module qam_symbol_mapper #(
  parameter int CAR_W = 12,
  parameter int AMP_W = 10,
  parameter int FRAC  = 4,
  parameter int SPS   = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [3:0]                     btn,
  input  logic                           bit_data,
  input  logic                           bit_valid,
  output logic                           bit_ready,
  input  logic                           car_valid,
  input  logic signed [CAR_W-1:0]        cos_in,
  input  logic signed [CAR_W-1:0]        sin_in,
  output logic                           out_valid,
  output logic signed [AMP_W+CAR_W-1:0]  i_out,
  output logic signed [AMP_W+CAR_W-1:0]  q_out,
  output logic [1:0]                     scheme
);
  localparam int PH_W = (SPS > 1) ? $clog2(SPS) : 1;
  localparam int SC   = 1 << (FRAC - 4);
  localparam logic signed [AMP_W-1:0] LV_BPSK = AMP_W'(2 * SC);
  localparam logic signed [AMP_W-1:0] LV_QPSK = AMP_W'(3 * SC);
  localparam logic signed [AMP_W-1:0] LV_LOW  = AMP_W'(5 * SC);
  localparam logic signed [AMP_W-1:0] LV_HIGH = AMP_W'(14 * SC);
  localparam logic signed [AMP_W-1:0] LV_UNIT = AMP_W'(16 * SC);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SPS - 1);

  function automatic logic [3:0] sym_bits(input logic [1:0] s);
    case (s)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      2'd2:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic signed [AMP_W-1:0] pm(input logic pos, input logic signed [AMP_W-1:0] m);
    return pos ? m : -m;
  endfunction

  function automatic logic signed [AMP_W-1:0] gray_amp(input logic [3:0] c);
    logic [3:0] x;
    logic [3:0] k;
    logic signed [5:0] odd;
    x = c ^ 4'b0001;
    k[3] = x[3];
    k[2] = k[3] ^ x[2];
    k[1] = k[2] ^ x[1];
    k[0] = k[1] ^ x[0];
    odd = $signed({1'b0, k, 1'b0}) - 6'sd15;
    return AMP_W'(odd) * LV_UNIT;
  endfunction

  logic [1:0]              next_sch;
  logic [PH_W-1:0]         ph;
  logic [3:0]              cnt;
  logic [7:0]              sh;
  logic signed [AMP_W-1:0] amp_i, amp_q;
  logic signed [AMP_W-1:0] map_i, map_q;
  logic [1:0]              btn_code;
  logic                    btn_ok;

  always_comb begin
    btn_ok   = 1'b1;
    btn_code = 2'd0;
    case (btn)
      4'b0000, 4'b1000: btn_code = 2'd0;
      4'b0100:          btn_code = 2'd1;
      4'b0010:          btn_code = 2'd2;
      4'b0001:          btn_code = 2'd3;
      default:          btn_ok   = 1'b0;
    endcase
  end

  wire [3:0] need     = sym_bits(next_sch);
  wire       full     = cnt >= need;
  wire       boundary = car_valid && (ph == PH_LAST);
  wire       take     = bit_valid && bit_ready;

  assign bit_ready = !full;

  always_comb begin
    case (next_sch)
      2'd0: begin
        map_i = pm(sh[0], LV_BPSK);
        map_q = '0;
      end
      2'd1: begin
        map_i = pm(sh[1], LV_QPSK);
        map_q = pm(sh[0], LV_QPSK);
      end
      2'd2: begin
        map_i = pm(sh[3], sh[2] ? LV_HIGH : LV_LOW);
        map_q = pm(sh[1], sh[0] ? LV_HIGH : LV_LOW);
      end
      default: begin
        map_i = gray_amp(sh[7:4]);
        map_q = gray_amp(sh[3:0]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_sch  <= 2'd0;
      scheme    <= 2'd0;
      ph        <= '0;
      cnt       <= '0;
      sh        <= '0;
      amp_i     <= '0;
      amp_q     <= '0;
      i_out     <= '0;
      q_out     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (btn_ok) next_sch <= btn_code;
      out_valid <= car_valid;
      if (car_valid) begin
        ph    <= (ph == PH_LAST) ? '0 : ph + PH_W'(1);
        i_out <= amp_i * cos_in;
        q_out <= amp_q * sin_in;
      end
      if (take) begin
        sh  <= {sh[6:0], bit_data};
        cnt <= cnt + 4'd1;
      end
      if (boundary) begin
        scheme <= next_sch;
        if (full) begin
          amp_i <= map_i;
          amp_q <= map_q;
          cnt   <= '0;
        end else begin
          amp_i <= '0;
          amp_q <= '0;
        end
      end
    end
  end

  a_r3_multi_press_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(btn) > 1) |=> $stable(next_sch));
  a_r4_scheme_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(scheme) && $stable(amp_i) && $stable(amp_q)));
  a_r5_bit_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !boundary) |=> (cnt == $past(cnt) + 4'd1));
  a_r6_bpsk_q_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (scheme == 2'd0) |-> (amp_q == '0));
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    car_valid |=> out_valid);
  a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !car_valid |=> !out_valid);
  a_r11_underrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !full) |=> (amp_i == '0 && amp_q == '0));
endmodule

// File: tb/tb_qam_symbol_mapper.sv
`timescale 1ns/1ps
module tb_qam_symbol_mapper;
  localparam int CW = 8;
  localparam int AW = 10;
  localparam int SPS = 16;
  localparam int OW = AW + CW;

  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] btn = 0;
  logic bit_data = 0, bit_valid = 0, car_valid = 0;
  logic signed [CW-1:0] cos_in = 0, sin_in = 0;
  logic bit_ready, out_valid;
  logic signed [OW-1:0] i_out, q_out;
  logic [1:0] scheme;

  always #10 clk = ~clk;

  qam_symbol_mapper #(.CAR_W(CW), .AMP_W(AW), .FRAC(4), .SPS(SPS)) dut (
    .clk(clk), .rst_n(rst_n), .btn(btn), .bit_data(bit_data), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .car_valid(car_valid), .cos_in(cos_in), .sin_in(sin_in),
    .out_valid(out_valid), .i_out(i_out), .q_out(q_out), .scheme(scheme));

  int checks = 0, errors = 0;
  bit done = 0;
  int m_next = 0, m_sch = 0, m_cnt = 0, m_ph = 0, m_ai = 0, m_aq = 0, m_i = 0, m_q = 0;
  bit m_v = 0;
  logic [7:0] m_sh = 0;
  string m_tag = "R1", m_otag = "R1";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int need_f(input int s);
    case (s) 0: return 1; 1: return 2; 2: return 4; default: return 8; endcase
  endfunction

  function automatic int gray_lvl(input logic [3:0] c);
    case (c)
      4'b0001: return -15; 4'b0000: return -13; 4'b0010: return -11; 4'b0011: return -9;
      4'b0111: return -7;  4'b0110: return -5;  4'b0100: return -3;  4'b0101: return -1;
      4'b1101: return 1;   4'b1100: return 3;   4'b1110: return 5;   4'b1111: return 7;
      4'b1011: return 9;   4'b1010: return 11;  4'b1000: return 13;  default: return 15;
    endcase
  endfunction

  function automatic int sg(input bit p, input int m);
    return p ? m : -m;
  endfunction

  task automatic map_sym(input int s, input logic [7:0] y, output int ai, output int aq);
    case (s)
      0: begin ai = sg(y[0], 2); aq = 0; end
      1: begin ai = sg(y[1], 3); aq = sg(y[0], 3); end
      2: begin ai = sg(y[3], y[2] ? 14 : 5); aq = sg(y[1], y[0] ? 14 : 5); end
      default: begin ai = 16 * gray_lvl(y[7:4]); aq = 16 * gray_lvl(y[3:0]); end
    endcase
  endtask

  function automatic string tag_of(input int s);
    case (s) 0: return "R6"; 1: return "R7"; 2: return "R8"; default: return "R9"; endcase
  endfunction

  task automatic step(input logic [3:0] b, input bit bv, input bit bd, input bit cv, input int c, input int s);
    bit rdy, bnd, full;
    int ni, nq;
    @(negedge clk);
    chk(out_valid == m_v, "R10", "out_valid", int'(out_valid), int'(m_v));
    chk(int'(i_out) == m_i, m_otag, "i_out", int'(i_out), m_i);
    chk(int'(q_out) == m_q, m_otag, "q_out", int'(q_out), m_q);
    chk(int'(scheme) == m_sch, "R4", "scheme", int'(scheme), m_sch);
    rdy = m_cnt < need_f(m_next);
    chk(bit_ready == rdy, "R5", "bit_ready", int'(bit_ready), int'(rdy));
    btn = b; bit_valid = bv; bit_data = bd; car_valid = cv;
    cos_in = CW'(c); sin_in = CW'(s);
    bnd = cv && (m_ph == SPS - 1);
    full = !rdy;
    m_v = cv;
    if (cv) begin
      m_i = m_ai * c; m_q = m_aq * s; m_otag = m_tag;
      m_ph = (m_ph == SPS - 1) ? 0 : m_ph + 1;
    end
    if (bv && !full) begin m_sh = {m_sh[6:0], bd}; m_cnt++; end
    if (bnd) begin
      m_sch = m_next;
      if (full) begin
        map_sym(m_next, m_sh, ni, nq);
        m_ai = ni; m_aq = nq; m_cnt = 0; m_tag = tag_of(m_next);
      end else begin
        m_ai = 0; m_aq = 0; m_tag = "R11";
      end
    end
    case (b)
      4'b0000, 4'b1000: m_next = 0;
      4'b0100: m_next = 1;
      4'b0010: m_next = 2;
      4'b0001: m_next = 3;
      default: ;
    endcase
  endtask

  function automatic int rcar();
    int r = $urandom % 8;
    if (r == 0) return -(1 << (CW - 1));
    if (r == 1) return (1 << (CW - 1)) - 1;
    return int'($urandom % (1 << CW)) - (1 << (CW - 1));
  endfunction

  initial begin
    logic [3:0] bl [5] = '{4'b0000, 4'b1000, 4'b0100, 4'b0010, 4'b0001};
    int          bx [5] = '{0, 0, 1, 2, 3};
    logic [3:0] cur;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(scheme == 2'd0, "R1", "scheme in reset", int'(scheme), 0);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(i_out == '0 && q_out == '0, "R1", "products in reset", int'(i_out), 0);
    chk(bit_ready == 1'b1, "R1", "bit_ready in reset", int'(bit_ready), 1);
    rst_n = 1;
    for (int k = 0; k < 5; k++) begin
      repeat (SPS + 2) step(bl[k], 1, 1'($urandom), 1, rcar(), rcar());
      chk(int'(scheme) == bx[k], "R2", "decoded scheme", int'(scheme), bx[k]);
    end
    repeat (2 * SPS) step(4'b0110, 1, 1'($urandom), 1, rcar(), rcar());
    chk(scheme == 2'd3, "R3", "scheme after multi-press", int'(scheme), 3);
    repeat (3 * SPS + 1) step(4'b0001, 0, 0, 1, 5, -7);
    chk(i_out == '0 && q_out == '0, "R11", "products after underrun", int'(i_out), 0);
    cur = 4'b0000;
    for (int n = 0; n < 20000; n++) begin
      if ($urandom % 150 == 0) begin
        int r = $urandom % 6;
        cur = (r < 5) ? bl[r] : 4'($urandom);
      end
      step(cur, ($urandom % 10) < 7, 1'($urandom), ($urandom % 10) < 8, rcar(), rcar());
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule